// File: doc/BRIEF.md
# Four-Lane Null-Suppression Unpacker

This block restores groups of four 32-bit integers from a compact byte stream in which each integer was stripped of up to three leading zero bytes. A group opens with one header byte that holds four 2-bit zero-byte counts, one per lane. The packed significant bytes of all four lanes follow, and their number is only known once the header has been read. The block takes the stream one byte per handshake, gathers the payload into a staging buffer in arrival order, then steers each byte to its lane and byte position, filling the stripped positions with zero.

Both edges are valid/ready streams. A byte moves on the input when `in_valid` and `in_ready` are both high at a rising clock edge; a group of four words leaves when `out_valid` and `out_ready` are both high. While a finished group waits, `in_ready` follows `out_ready`. The input therefore stalls whenever the consumer stalls, and the header of the next group can enter on the same edge that releases the previous group. The output is a single 128-bit word with lane 0 in bits 31:0 and lane 3 in bits 127:96.

Top module: `nsup_unpack4`

## Requirements
- R1: During and after reset `out_valid` is 0 and `in_ready` is 1. A reset in the middle of a group discards that group, and the next byte accepted is taken as a header.
- R2: In the header byte, bits 7:6 hold the zero-byte count for lane 0 (`out_lanes[31:0]`), bits 5:4 for lane 1, bits 3:2 for lane 2 and bits 1:0 for lane 3 (`out_lanes[127:96]`).
- R3: Lane payload is taken in lane order, lane 0 first. A lane with count z takes 4−z payload bytes. The first of these bytes lands in the lane's most significant kept position and the last in bits 7:0. The top z bytes of the lane are zero.
- R4: After a header, exactly 16 minus the sum of the four counts payload bytes are accepted. `out_valid` is 0 up to the edge that accepts the last of them and is 1 right after that edge.
- R5: Header 0x00 takes 16 payload bytes and yields four full words. Header 0xFF takes 4 payload bytes, one per lane.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_lanes` does not change, and `in_ready` is 0.
- R7: When `out_valid`, `out_ready` and `in_valid` are all 1, the group leaves and the input byte is taken as the next header on the same edge.
- R8: Cycles with `in_valid` low, before or between payload bytes, change neither the byte count nor the result.
- R9: A lane with count 3 keeps its last byte even when that byte is 0x00, and the byte still counts toward the payload length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Header or payload byte |
| out_valid | output | 1 | A restored group is presented |
| out_ready | input | 1 | Consumer takes the group |
| out_lanes | output | 128 | Four restored words, lane 0 in bits 31:0 |

## Verification
On every cycle, the assertions check the back-pressure rules: the output holds still and the input is blocked while a group waits. They also check that the staging count never exceeds the buffer, that a presented group holds exactly the number of bytes its header asks for, and that a back-to-back handover restarts collection from zero. Only the bench scenarios can show the lane values themselves. These cover the field order in the header, byte order inside a lane, all-full and all-stripped headers, a kept zero byte, idle gaps, a stalled consumer with the next header waiting, and a reset in the middle of a group.

// File: rtl/nsup_pkg.sv
package nsup_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_FILL = 2'd1,
    ST_SHOW = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/nsup_hdr_decode.sv
// Turns the header byte into per-lane byte counts, lane offsets in the
// staging buffer and the total payload length.
module nsup_hdr_decode #(
  parameter int LANES      = 4,
  parameter int LANE_BYTES = 4
) (
  input  logic [LANES*$clog2(LANE_BYTES)-1:0]        hdr,
  output logic [$clog2(LANE_BYTES+1)-1:0]            lane_n   [LANES],
  output logic [$clog2(LANES*LANE_BYTES)-1:0]        lane_off [LANES],
  output logic [$clog2(LANES*LANE_BYTES+1)-1:0]      total
);
  localparam int ZW   = $clog2(LANE_BYTES);
  localparam int NW   = $clog2(LANE_BYTES+1);
  localparam int IDXW = $clog2(LANES*LANE_BYTES);
  localparam int CNTW = $clog2(LANES*LANE_BYTES+1);

  // Lane 0 sits in the most significant field of the header.
  for (genvar k = 0; k < LANES; k++) begin : g_cnt
    logic [ZW-1:0] zeros;
    assign zeros     = hdr[(LANES-1-k)*ZW +: ZW];
    assign lane_n[k] = NW'(LANE_BYTES) - NW'(zeros);
  end

  always_comb begin
    logic [CNTW-1:0] run;
    run = '0;
    for (int k = 0; k < LANES; k++) begin
      lane_off[k] = IDXW'(run);
      run         = run + CNTW'(lane_n[k]);
    end
    total = run;
  end
endmodule

// File: rtl/nsup_stage.sv
// Staging buffer: payload bytes are written in arrival order.
module nsup_stage #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_byte,
  output logic [DW-1:0]                mem [DEPTH],
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH+1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (wr_en) begin
      cnt <= cnt + CNTW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt[IDXW-1:0]] <= wr_byte;
  end

  // R4: no write lands past the end of the buffer
  p_stage_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt < CNTW'(DEPTH)));

  // R1: clear and write never collide
  p_clr_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && wr_en));
endmodule

// File: rtl/nsup_route.sv
// Steers staged bytes back to lane positions; stripped positions read zero.
module nsup_route #(
  parameter int LANES      = 4,
  parameter int LANE_BYTES = 4,
  parameter int DW         = 8
) (
  input  logic [DW-1:0]                         mem      [LANES*LANE_BYTES],
  input  logic [$clog2(LANE_BYTES+1)-1:0]       lane_n   [LANES],
  input  logic [$clog2(LANES*LANE_BYTES)-1:0]   lane_off [LANES],
  output logic [LANES*LANE_BYTES*DW-1:0]        lanes
);
  localparam int NW     = $clog2(LANE_BYTES+1);
  localparam int IDXW   = $clog2(LANES*LANE_BYTES);
  localparam int LANE_W = LANE_BYTES*DW;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
      logic [IDXW-1:0] src;
      // Byte b counts from the least significant end; the last payload
      // byte of the lane is its bits 7:0.
      assign src = lane_off[k] + IDXW'(lane_n[k]) - IDXW'(1) - IDXW'(b);
      assign lanes[k*LANE_W + b*DW +: DW] =
        (NW'(b) < lane_n[k]) ? mem[src] : '0;
    end
  end
endmodule

// File: rtl/nsup_unpack4.sv
module nsup_unpack4 #(
  parameter int LANES      = 4,
  parameter int LANE_BYTES = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       in_valid,
  output logic                                       in_ready,
  input  logic [7:0]                                 in_data,
  output logic                                       out_valid,
  input  logic                                       out_ready,
  output logic [LANES*LANE_BYTES*8-1:0]              out_lanes
);
  import nsup_pkg::*;

  localparam int ZW     = $clog2(LANE_BYTES);
  localparam int HDR_W  = LANES*ZW;
  localparam int DEPTH  = LANES*LANE_BYTES;
  localparam int NW     = $clog2(LANE_BYTES+1);
  localparam int IDXW   = $clog2(DEPTH);
  localparam int CNTW   = $clog2(DEPTH+1);

  ctl_state_t        state;
  logic [HDR_W-1:0]  hdr_q;
  logic [NW-1:0]     lane_n   [LANES];
  logic [IDXW-1:0]   lane_off [LANES];
  logic [CNTW-1:0]   total;
  logic [CNTW-1:0]   fill_cnt;
  logic [BYTE_W-1:0] stage_mem [DEPTH];
  logic              take, take_hdr, take_pay;

  assign out_valid = (state == ST_SHOW);
  assign in_ready  = (state != ST_SHOW) || out_ready;
  assign take      = in_valid && in_ready;
  assign take_hdr  = take && (state != ST_FILL);
  assign take_pay  = take && (state == ST_FILL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_HDR;
      hdr_q <= '0;
    end else begin
      if (take_hdr) hdr_q <= in_data[HDR_W-1:0];
      unique case (state)
        ST_HDR:  if (take) state <= ST_FILL;
        ST_FILL: if (take && fill_cnt == total - CNTW'(1)) state <= ST_SHOW;
        ST_SHOW: if (out_ready) state <= in_valid ? ST_FILL : ST_HDR;
        default: state <= ST_HDR;
      endcase
    end
  end

  nsup_hdr_decode #(.LANES(LANES), .LANE_BYTES(LANE_BYTES)) u_dec (
    .hdr      (hdr_q),
    .lane_n   (lane_n),
    .lane_off (lane_off),
    .total    (total)
  );

  nsup_stage #(.DEPTH(DEPTH), .DW(BYTE_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (take_hdr),
    .wr_en   (take_pay),
    .wr_byte (in_data),
    .mem     (stage_mem),
    .cnt     (fill_cnt)
  );

  nsup_route #(.LANES(LANES), .LANE_BYTES(LANE_BYTES), .DW(BYTE_W)) u_route (
    .mem      (stage_mem),
    .lane_n   (lane_n),
    .lane_off (lane_off),
    .lanes    (out_lanes)
  );

  // R6: a waiting group holds still
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lanes)));

  // R6: input blocked while the group waits
  p_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4: a presented group holds exactly the bytes its header asks for
  p_len_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fill_cnt == total));

  // R7: back-to-back handover restarts collection from zero
  p_b2b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_valid) |=> (!out_valid && fill_cnt == '0));

  // R5: payload length stays between one and four bytes per lane
  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_HDR) |-> (total >= CNTW'(LANES) && total <= CNTW'(DEPTH)));
endmodule

// File: tb/nsup_unpack4_test.sv
`timescale 1ns/1ps
module nsup_unpack4_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [7:0]   in_data;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_lanes;

  int total_chk = 0;
  int bad_chk   = 0;

  always #2.5 clk = ~clk;

  nsup_unpack4 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_lanes(out_lanes)
  );

  localparam int NV = 5;
  // Payload is left-aligned: first byte in bits 127:120.
  // Expected is {lane3, lane2, lane1, lane0}.
  localparam logic [7:0] V_HDR [NV] = '{8'hB7, 8'h00, 8'hFF, 8'h1B, 8'hE4};
  localparam logic [127:0] V_PAY [NV] = '{
    {56'h011F0004B5B004, 72'h0},                    // R9: kept zero byte
    128'h112233445566778899AABBCCDDEEF001,          // R5: all full
    {32'hA1B2C3D4, 96'h0},                          // R5: all stripped
    {80'h0102030405060708090A, 48'h0},              // R2: field order
    {80'h5A6B7C8D9EAF10213243, 48'h0}               // R2: reversed order
  };
  localparam logic [127:0] V_EXP [NV] = '{
    {32'h00000004, 32'h0004B5B0, 32'h00000000, 32'h0000011F},
    {32'hDDEEF001, 32'h99AABBCC, 32'h55667788, 32'h11223344},
    {32'h000000D4, 32'h000000C3, 32'h000000B2, 32'h000000A1},
    {32'h0000000A, 32'h00000809, 32'h00050607, 32'h01020304},
    {32'h10213243, 32'h008D9EAF, 32'h00006B7C, 32'h0000005A}
  };

  function automatic int plen(input logic [7:0] h);
    return 16 - int'(h[7:6]) - int'(h[5:4]) - int'(h[3:2]) - int'(h[1:0]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after a falling edge.
  task automatic push(input logic [7:0] b, input int gap);
    bit ok;
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    do begin
      #1 ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic send_pay(input logic [7:0] h, input logic [127:0] pay,
                          input int gap, input string tag);
    int n;
    n = plen(h);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1)
        chk(out_valid == 1'b0, {tag, " R4 early valid"}, 128'(out_valid), 128'd0);
      push(pay[127 - 8*i -: 8], gap);
    end
    chk(out_valid == 1'b1, {tag, " R4 valid after last"}, 128'(out_valid), 128'd1);
  endtask

  task automatic pop;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad_chk++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 valid in reset", 128'(out_valid), 128'd0);
    chk(in_ready == 1'b1, "R1 ready in reset", 128'(in_ready), 128'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset",
        {126'd0, out_valid, in_ready}, 128'd1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (i == 0) ? "R9" : ((i == 1 || i == 2) ? "R5" : "R2");
      push(V_HDR[i], 0);
      send_pay(V_HDR[i], V_PAY[i], 0, tag);
      chk(out_lanes == V_EXP[i], {tag, " R3 lanes"}, out_lanes, V_EXP[i]);
      pop();
      chk(out_valid == 1'b0, {tag, " R4 released"}, 128'(out_valid), 128'd0);
    end

    // R8: idle gaps everywhere
    push(V_HDR[4], 3);
    send_pay(V_HDR[4], V_PAY[4], 2, "R8");
    chk(out_lanes == V_EXP[4], "R8 lanes with gaps", out_lanes, V_EXP[4]);
    pop();

    // R6 stall with next header waiting, then R7 handover
    push(V_HDR[3], 0);
    send_pay(V_HDR[3], V_PAY[3], 0, "R6");
    in_valid = 1'b1;
    in_data  = V_HDR[0];
    for (int c = 0; c < 4; c++) begin
      #1;
      chk(in_ready == 1'b0, "R6 input blocked", 128'(in_ready), 128'd0);
      chk(out_valid == 1'b1 && out_lanes == V_EXP[3], "R6 output held",
          out_lanes, V_EXP[3]);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1 chk(in_ready == 1'b1, "R7 ready follows consumer", 128'(in_ready), 128'd1);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b0;
    chk(out_valid == 1'b0, "R7 group left", 128'(out_valid), 128'd0);
    send_pay(V_HDR[0], V_PAY[0], 0, "R7");
    chk(out_lanes == V_EXP[0], "R7 lanes after handover", out_lanes, V_EXP[0]);
    pop();

    // R1: reset in the middle of a group
    push(V_HDR[1], 0);
    push(8'h77, 0);
    push(8'h66, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 mid-group reset",
        {126'd0, out_valid, in_ready}, 128'd1);
    push(V_HDR[2], 0);
    send_pay(V_HDR[2], V_PAY[2], 0, "R1");
    chk(out_lanes == V_EXP[2], "R1 fresh group after reset", out_lanes, V_EXP[2]);
    pop();

    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule